// File: doc/BRIEF.md
# Flash Fire Gate with Charge Interlock

This block sits between the camera's trigger inputs and the logic-level enable of the xenon flash gate driver. It merges a group of trigger lines into one effective fire request. Whether that request may reach the gate driver depends on the charger state. While the charger is switched off (standby), the drive always follows the request. During the first charge after enable, before the target voltage is reached, firing is locked out and triggers are ignored. Once the target has been reached, the charger enters regulation and firing is allowed again.

In regulation the charger may be running a refresh burst when the trigger arrives. In that case the block raises a halt request to the charge controller. It holds the drive off until the controller acknowledges that switching has stopped, and then fires. If no refresh is running, it fires at once. In both cases the halt request stays up for as long as the trigger is high, so it also blocks any new refresh. When the trigger falls, the halt request and the drive are released together and charging may resume.

The trigger lines are asynchronous and pass through synchronisers. The enable, done, refresh and acknowledge inputs come from logic on the same clock. Firing works on the level of the trigger, not on its edge, so a trigger that is already high when the lockout ends is still honoured.

Top module: `flash_fire_gate`

## Requirements
- R1: The effective trigger is the AND of all trigger inputs `trig_i`. With any one of them low, `fire_o` stays 0.
- R2: With `chg_en_i` = 0 (standby), `fire_o` equals the effective trigger, whatever `done_i` is, and `halt_o` is 0. A trigger change shows on `fire_o` three clock edges after it is applied (two synchroniser stages plus one output register).
- R3: With `chg_en_i` = 1 and `done_i` = 0 (initial charge), `fire_o` and `halt_o` are 0 from the next clock edge on, whatever the triggers do.
- R4: In regulation (`chg_en_i` = 1, `done_i` = 1) with `refresh_i` = 0, a trigger raises both `fire_o` and `halt_o` three edges after it is applied.
- R5: In regulation with `refresh_i` = 1, a trigger raises `halt_o` but keeps `fire_o` at 0 while `sw_idle_i` = 0. `fire_o` rises on the first edge at which `sw_idle_i` is sampled 1, which is one clock after the acknowledge appears.
- R6: `halt_o` stays 1 for as long as the effective trigger is high in regulation. Three edges after the trigger falls, `halt_o` and `fire_o` both return to 0.
- R7: A trigger that is already high when `done_i` rises is accepted. `fire_o` and `halt_o` rise on the first edge after `done_i` rises.
- R8: Once `fire_o` is 1 in regulation, it stays 1 while the trigger is high, even if `refresh_i` rises and `sw_idle_i` falls.
- R9: While `rst_n` is low, `fire_o` and `halt_o` are 0 and the synchronisers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | N_TRIG | Asynchronous trigger lines, combined by AND |
| chg_en_i | input | 1 | Charger enable; 0 means standby |
| done_i | input | 1 | Target voltage reached since enable (regulation phase) |
| refresh_i | input | 1 | Charge controller is running a refresh burst |
| sw_idle_i | input | 1 | Charge controller acknowledges that switching has stopped |
| halt_o | output | 1 | Request to halt and block charging |
| fire_o | output | 1 | Logic-level enable for the flash gate driver |

## Verification
Results are due at two different latencies. A change on the trigger lines reaches `fire_o` and `halt_o` on the third edge after it is applied. A change on enable, done, refresh or the acknowledge shows on the first edge. The bench drives every input on a falling edge and samples on a later falling edge. For each latency it checks the value both just before the due edge and just after it. The stimulus table holds each vector for several cycles, so that both paths have settled before the sample. The directed tests then count the edges one at a time.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY  = 2'd0,
    MODE_LOCKED   = 2'd1,
    MODE_REGULATE = 2'd2
  } gate_mode_t;

  // Charger state seen by the gate: off, first charge, or holding target.
  function automatic gate_mode_t decode_mode(input logic en, input logic done);
    if (!en)       return MODE_STANDBY;
    else if (!done) return MODE_LOCKED;
    else           return MODE_REGULATE;
  endfunction

  // Next drive value: in regulation a running refresh must be acknowledged
  // first; once fired, the drive holds until the trigger ends.
  function automatic logic next_fire(input gate_mode_t mode, input logic trig,
                                     input logic fire_q, input logic refresh,
                                     input logic idle);
    case (mode)
      MODE_STANDBY:  return trig;
      MODE_REGULATE: return trig && (fire_q || !refresh || idle);
      default:       return 1'b0;
    endcase
  endfunction

  // Halt request covers the whole trigger in regulation.
  function automatic logic next_halt(input gate_mode_t mode, input logic trig);
    return (mode == MODE_REGULATE) && trig;
  endfunction

endpackage

// File: rtl/flash_trig_sync.sv
module flash_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/flash_gate_core.sv
module flash_gate_core
  import flash_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_eff_i,
  input  gate_mode_t mode_i,
  input  logic       refresh_i,
  input  logic       sw_idle_i,
  output logic       fire_o,
  output logic       halt_o
);
  logic fire_q, halt_q;
  logic fire_d, halt_d;

  always_comb begin
    fire_d = next_fire(mode_i, trig_eff_i, fire_q, refresh_i, sw_idle_i);
    halt_d = next_halt(mode_i, trig_eff_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      halt_q <= halt_d;
    end
  end

  assign fire_o = fire_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/flash_fire_gate.sv
module flash_fire_gate
  import flash_gate_pkg::*;
#(
  parameter int N_TRIG      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              chg_en_i,
  input  logic              done_i,
  input  logic              refresh_i,
  input  logic              sw_idle_i,
  output logic              halt_o,
  output logic              fire_o
);
  logic [N_TRIG-1:0] trig_sync;
  logic              trig_eff;
  gate_mode_t        mode;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sync
    flash_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (trig_i[g]),
      .q_o  (trig_sync[g])
    );
  end

  assign trig_eff = &trig_sync;
  assign mode     = decode_mode(chg_en_i, done_i);

  flash_gate_core core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_eff_i(trig_eff),
    .mode_i    (mode),
    .refresh_i (refresh_i),
    .sw_idle_i (sw_idle_i),
    .fire_o    (fire_o),
    .halt_o    (halt_o)
  );
endmodule

// File: rtl/flash_fire_gate_chk.sv
module flash_fire_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic chg_en_i,
  input logic done_i,
  input logic refresh_i,
  input logic sw_idle_i,
  input logic trig_eff,
  input logic fire_o,
  input logic halt_o
);
  // R1: drive only follows an effective (all-high) synchronised trigger
  a_r1_fire_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(trig_eff));

  // R2: standby never requests a halt
  a_r2_standby_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en_i |=> !halt_o);

  // R3: initial charge keeps both outputs quiet
  a_r3_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en_i && !done_i) |=> (!fire_o && !halt_o));

  // R5: an unacknowledged refresh holds the drive off
  a_r5_wait_for_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en_i && done_i && refresh_i && !sw_idle_i && !fire_o) |=> !fire_o);

  // R6: trigger gone means release on the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_eff |=> (!fire_o && !halt_o));

  // R8: once firing in regulation, keep firing while the trigger is high
  a_r8_fire_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && chg_en_i && done_i && trig_eff) |=> fire_o);
endmodule

bind flash_fire_gate flash_fire_gate_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .chg_en_i (chg_en_i),
  .done_i   (done_i),
  .refresh_i(refresh_i),
  .sw_idle_i(sw_idle_i),
  .trig_eff (trig_eff),
  .fire_o   (fire_o),
  .halt_o   (halt_o)
);

// File: tb/flash_fire_gate_tb_top.sv
module flash_fire_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] trig = 2'b00;
  logic       en = 1'b0, done = 1'b0, refresh = 1'b0, idle = 1'b1;
  logic       halt, fire;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  flash_fire_gate #(.N_TRIG(2), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .chg_en_i(en), .done_i(done),
    .refresh_i(refresh), .sw_idle_i(idle), .halt_o(halt), .fire_o(fire)
  );

  // {req[3:0], en, done, trig_a, trig_b, exp_fire, exp_halt}; refresh 0
  localparam logic [9:0] VEC [9] = '{
    {4'd2, 6'b00_11_10},   // R2 standby follows trigger
    {4'd1, 6'b00_10_00},   // R1 one line low
    {4'd1, 6'b00_01_00},   // R1 other line low
    {4'd2, 6'b01_11_10},   // R2 done ignored in standby
    {4'd3, 6'b10_11_00},   // R3 locked
    {4'd3, 6'b10_01_00},   // R3 locked
    {4'd4, 6'b11_11_11},   // R4 regulation fires, halts
    {4'd1, 6'b11_10_00},   // R1 partial trigger in regulation
    {4'd2, 6'b01_00_00}    // R2 idle standby
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    trig = 2'b11;
    step(3);
    chk("R9", fire, 1'b0, "fire in reset");
    chk("R9", halt, 1'b0, "halt in reset");
    trig = 2'b00;
    step(1);
    rst_n = 1'b1;
    step(2);

    for (int i = 0; i < 9; i++) begin
      {en, done, trig} = VEC[i][5:2];
      step(5);
      chk($sformatf("R%0d", VEC[i][9:6]), fire, VEC[i][1], $sformatf("table %0d fire", i));
      chk($sformatf("R%0d", VEC[i][9:6]), halt, VEC[i][0], $sformatf("table %0d halt", i));
    end

    // R2 latency: third edge after the trigger change
    en = 0; done = 0; trig = 2'b00; step(4);
    trig = 2'b11;
    step(2); chk("R2", fire, 1'b0, "before third edge");
    step(1); chk("R2", fire, 1'b1, "at third edge");

    // R5 refresh handshake
    trig = 2'b00; en = 1; done = 1; refresh = 1; idle = 0; step(4);
    trig = 2'b11;
    step(2); chk("R5", halt, 1'b0, "halt before third edge");
    step(1); chk("R5", halt, 1'b1, "halt at third edge");
    chk("R5", fire, 1'b0, "fire held off");
    step(5); chk("R5", fire, 1'b0, "fire still waiting");
    idle = 1;
    step(1); chk("R5", fire, 1'b1, "fire one edge after ack");
    // R8 drive stays while refresh reasserts
    idle = 0;
    step(3); chk("R8", fire, 1'b1, "fire sticky");
    // R6 release
    trig = 2'b01;
    step(2); chk("R6", halt, 1'b1, "halt held before release edge");
    chk("R6", fire, 1'b1, "fire held before release edge");
    step(1); chk("R6", halt, 1'b0, "halt released");
    chk("R6", fire, 1'b0, "fire released");

    // R7 trigger already high when lock lifts
    refresh = 0; idle = 1; done = 0; trig = 2'b11; step(5);
    chk("R7", fire, 1'b0, "locked before done");
    done = 1;
    step(1); chk("R7", fire, 1'b1, "fire after done rises");
    chk("R7", halt, 1'b1, "halt after done rises");

    // R3 lock takes effect on the next edge
    done = 0;
    step(1); chk("R3", fire, 1'b0, "fire dropped by lock");
    chk("R3", halt, 1'b0, "halt dropped by lock");

    // R9 reset mid-run
    en = 0; step(4);
    chk("R2", fire, 1'b1, "standby fire before reset");
    rst_n = 0; #1;
    chk("R9", fire, 1'b0, "fire cleared by reset");
    rst_n = 1; step(1);
    chk("R9", fire, 1'b0, "synchroniser cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule